// File: doc/BRIEF.md
# Trap Return Unit

This block carries out the two trap-return operations of a hart: the return from a supervisor-level trap handler and the return from a machine-level trap handler. On a request strobe it checks that the current privilege is high enough for the requested level. It selects the saved exception PC of that level and, when the core cannot run compressed instructions, checks that this PC is word aligned. If both checks pass, it pops the interrupt-enable stack of that level in the status word, resets the saved previous-privilege field to user mode, and switches to the privilege the field held before. It also presents the saved PC as the redirect target.

All results are registered and appear one clock after the strobe. A successful return is reported by a one-cycle done pulse, together with the new status word, privilege and target PC. A rejected return is reported by a one-cycle fault pulse and a cause code. In that case the status word and privilege are passed through unchanged. The pipeline flush and trap entry belong to neighbouring logic.

Top module: `trap_return_unit`

## Requirements
- R1: After reset, done and fault are 0, the privilege output is 3 (machine), and the status, target PC and cause outputs are 0.
- R2: A supervisor return (`ret_is_m_i`=0) requested at privilege 0 (user) gives a fault with cause 2 (illegal instruction). The status output equals the input status and the privilege output equals the current privilege.
- R3: A machine return (`ret_is_m_i`=1) requested at any privilege below 3 gives a fault with cause 2. Status and privilege are unchanged.
- R4: When `rvc_en_i` is 0 and the selected saved PC has bit 1 or bit 0 set, the return gives a fault with cause 0 (instruction address misaligned). Status and privilege are unchanged.
- R5: When `rvc_en_i` is 1, the alignment of the saved PC is not checked.
- R6: A successful machine return writes the old MPIE (bit 7) into MIE (bit 3), clears MPIE, and sets MPP (bits 12:11) to 0.
- R7: A successful supervisor return writes the old SPIE (bit 5) into SIE (bit 1), clears SPIE, and sets SPP (bit 8) to 0.
- R8: The new privilege is the old MPP (machine return) or the old SPP zero-extended (supervisor return). An MPP value of 2 gives privilege 1.
- R9: On success, the target PC is `mepc_i` for a machine return and `sepc_i` for a supervisor return.
- R10: All status bits other than the fields named in R6 and R7 pass through a successful return unchanged.
- R11: When a request has both a privilege fault and a misaligned PC, the cause is 2.
- R12: In a cycle after no request, done and fault are 0. The target PC keeps its last value on faults and idle cycles. The cause keeps its last value on successes and idle cycles.
- R13: Results appear on the outputs at the first clock edge after the strobe, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid_i | input | 1 | Return request strobe |
| ret_is_m_i | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| status_i | input | XLEN | Current status word |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| rvc_en_i | input | 1 | Compressed instructions supported |
| ret_done_o | output | 1 | Return completed (one cycle) |
| ret_fault_o | output | 1 | Return rejected (one cycle) |
| fault_cause_o | output | 4 | Exception cause of the last fault |
| status_o | output | XLEN | New status word |
| priv_o | output | 2 | New privilege |
| target_pc_o | output | XLEN | Redirect PC |

## Verification
The privilege check and the alignment check can both trip on the same request. An example is a machine return issued from user mode while compressed support is off and the saved PC is odd. Directed cases build exactly this overlap, and random stimulus keeps producing it by drawing privilege, saved PCs and the compressed flag independently. The bench judges each response against a model that gives the privilege fault precedence. It expects cause 2 and an unchanged status and privilege whenever the two conditions coincide.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int unsigned CAUSE_W = 4;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // status word field positions decoded by neighbouring logic
  localparam int unsigned ST_SIE    = 1;
  localparam int unsigned ST_MIE    = 3;
  localparam int unsigned ST_SPIE   = 5;
  localparam int unsigned ST_MPIE   = 7;
  localparam int unsigned ST_SPP    = 8;
  localparam int unsigned ST_MPP_LO = 11;
  localparam int unsigned ST_MPP_HI = 12;

  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;
endpackage

// File: rtl/trp_gate.sv
module trp_gate
  import trp_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic                ret_is_m,
  input  logic [1:0]          cur_priv,
  input  logic [XLEN-1:0]     sepc,
  input  logic [XLEN-1:0]     mepc,
  input  logic                rvc_en,
  output logic [XLEN-1:0]     epc_sel,
  output logic                fault,
  output logic [CAUSE_W-1:0]  cause
);
  logic [1:0] need_priv;
  logic       priv_low;
  logic       misaligned;

  always_comb begin
    need_priv  = ret_is_m ? 2'(PRIV_M) : 2'(PRIV_S);
    priv_low   = (cur_priv < need_priv);
    epc_sel    = ret_is_m ? mepc : sepc;
    misaligned = !rvc_en && (|epc_sel[ALIGN_BITS-1:0]);
    fault      = priv_low || misaligned;
    // privilege violation outranks the alignment check
    cause      = priv_low ? CAUSE_ILLEGAL : CAUSE_MISALIGN;
  end
endmodule

// File: rtl/trp_stack.sv
module trp_stack
  import trp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            ret_is_m,
  input  logic [XLEN-1:0] status_in,
  output logic [XLEN-1:0] status_nxt,
  output logic [1:0]      priv_nxt
);
  logic [1:0] m_prev;
  logic [1:0] s_prev;

  always_comb begin
    m_prev     = status_in[ST_MPP_HI:ST_MPP_LO];
    s_prev     = {1'b0, status_in[ST_SPP]};
    status_nxt = status_in;
    if (ret_is_m) begin
      status_nxt[ST_MIE]              = status_in[ST_MPIE];
      status_nxt[ST_MPIE]             = 1'b0;
      status_nxt[ST_MPP_HI:ST_MPP_LO] = 2'(PRIV_U);
      // reserved level folds onto supervisor
      priv_nxt = (m_prev == 2'(PRIV_RSVD)) ? 2'(PRIV_S) : m_prev;
    end else begin
      status_nxt[ST_SIE]  = status_in[ST_SPIE];
      status_nxt[ST_SPIE] = 1'b0;
      status_nxt[ST_SPP]  = 1'b0;
      priv_nxt = s_prev;
    end
  end
endmodule

// File: rtl/trp_commit.sv
module trp_commit
  import trp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid,
  input  logic               fault,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    status_cur,
  input  logic [1:0]         priv_cur,
  input  logic [XLEN-1:0]    status_nxt,
  input  logic [1:0]         priv_nxt,
  input  logic [XLEN-1:0]    epc_sel,
  output logic               done_q,
  output logic               fault_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    status_q,
  output logic [1:0]         priv_q,
  output logic [XLEN-1:0]    pc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      cause_q  <= '0;
      status_q <= '0;
      priv_q   <= 2'(PRIV_M);
      pc_q     <= '0;
    end else begin
      done_q  <= valid && !fault;
      fault_q <= valid && fault;
      if (valid) begin
        if (fault) begin
          cause_q  <= cause;
          status_q <= status_cur;
          priv_q   <= priv_cur;
        end else begin
          status_q <= status_nxt;
          priv_q   <= priv_nxt;
          pc_q     <= epc_sel;
        end
      end
    end
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ret_valid_i,
  input  logic               ret_is_m_i,
  input  logic [1:0]         cur_priv_i,
  input  logic [XLEN-1:0]    status_i,
  input  logic [XLEN-1:0]    sepc_i,
  input  logic [XLEN-1:0]    mepc_i,
  input  logic               rvc_en_i,
  output logic               ret_done_o,
  output logic               ret_fault_o,
  output logic [CAUSE_W-1:0] fault_cause_o,
  output logic [XLEN-1:0]    status_o,
  output logic [1:0]         priv_o,
  output logic [XLEN-1:0]    target_pc_o
);
  logic [XLEN-1:0]    epc_sel;
  logic               fault;
  logic [CAUSE_W-1:0] cause;
  logic [XLEN-1:0]    status_nxt;
  logic [1:0]         priv_nxt;

  trp_gate #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_gate (
    .ret_is_m (ret_is_m_i),
    .cur_priv (cur_priv_i),
    .sepc     (sepc_i),
    .mepc     (mepc_i),
    .rvc_en   (rvc_en_i),
    .epc_sel  (epc_sel),
    .fault    (fault),
    .cause    (cause)
  );

  trp_stack #(.XLEN(XLEN)) u_stack (
    .ret_is_m   (ret_is_m_i),
    .status_in  (status_i),
    .status_nxt (status_nxt),
    .priv_nxt   (priv_nxt)
  );

  trp_commit #(.XLEN(XLEN)) u_commit (
    .clk        (clk),
    .rst        (rst),
    .valid      (ret_valid_i),
    .fault      (fault),
    .cause      (cause),
    .status_cur (status_i),
    .priv_cur   (cur_priv_i),
    .status_nxt (status_nxt),
    .priv_nxt   (priv_nxt),
    .epc_sel    (epc_sel),
    .done_q     (ret_done_o),
    .fault_q    (ret_fault_o),
    .cause_q    (fault_cause_o),
    .status_q   (status_o),
    .priv_q     (priv_o),
    .pc_q       (target_pc_o)
  );
endmodule

// File: rtl/trap_return_chk.sv
module trap_return_chk
  import trp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               ret_valid_i,
  input logic               ret_is_m_i,
  input logic [1:0]         cur_priv_i,
  input logic [XLEN-1:0]    status_i,
  input logic [XLEN-1:0]    sepc_i,
  input logic [XLEN-1:0]    mepc_i,
  input logic               rvc_en_i,
  input logic               ret_done_o,
  input logic               ret_fault_o,
  input logic [CAUSE_W-1:0] fault_cause_o,
  input logic [XLEN-1:0]    status_o,
  input logic [1:0]         priv_o,
  input logic [XLEN-1:0]    target_pc_o
);
  logic            q_valid, q_is_m, q_rvc;
  logic [1:0]      q_cur;
  logic [XLEN-1:0] q_status, q_sepc, q_mepc;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_is_m   <= 1'b0;
      q_rvc    <= 1'b0;
      q_cur    <= '0;
      q_status <= '0;
      q_sepc   <= '0;
      q_mepc   <= '0;
    end else begin
      q_valid  <= ret_valid_i;
      q_is_m   <= ret_is_m_i;
      q_rvc    <= rvc_en_i;
      q_cur    <= cur_priv_i;
      q_status <= status_i;
      q_sepc   <= sepc_i;
      q_mepc   <= mepc_i;
    end
  end

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ret_done_o && ret_fault_o)); // R2

  AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    (ret_fault_o && fault_cause_o == CAUSE_ILLEGAL) |-> (priv_o == q_cur && status_o == q_status)); // R3

  AST_CAUSE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    ret_fault_o |-> (fault_cause_o == CAUSE_ILLEGAL || fault_cause_o == CAUSE_MISALIGN)); // R4

  AST_ALIGNED_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ret_done_o && !q_rvc) |-> (target_pc_o[1:0] == 2'b00)); // R4

  AST_MRET_POP: assert property (@(posedge clk) disable iff (rst)
    (ret_done_o && q_is_m) |-> (status_o[ST_MPIE] == 1'b0 && status_o[ST_MPP_HI:ST_MPP_LO] == 2'b00
                                && status_o[ST_MIE] == q_status[ST_MPIE])); // R6

  AST_SRET_POP: assert property (@(posedge clk) disable iff (rst)
    (ret_done_o && !q_is_m) |-> (status_o[ST_SPIE] == 1'b0 && status_o[ST_SPP] == 1'b0
                                 && status_o[ST_SIE] == q_status[ST_SPIE])); // R7

  AST_PRIV_NOT_RSVD: assert property (@(posedge clk) disable iff (rst)
    ret_done_o |-> (priv_o != 2'(PRIV_RSVD))); // R8

  AST_TARGET_SEL: assert property (@(posedge clk) disable iff (rst)
    ret_done_o |-> (target_pc_o == (q_is_m ? q_mepc : q_sepc))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !q_valid |-> (!ret_done_o && !ret_fault_o)); // R12
endmodule

bind trap_return_unit trap_return_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ret_valid_i   (ret_valid_i),
  .ret_is_m_i    (ret_is_m_i),
  .cur_priv_i    (cur_priv_i),
  .status_i      (status_i),
  .sepc_i        (sepc_i),
  .mepc_i        (mepc_i),
  .rvc_en_i      (rvc_en_i),
  .ret_done_o    (ret_done_o),
  .ret_fault_o   (ret_fault_o),
  .fault_cause_o (fault_cause_o),
  .status_o      (status_o),
  .priv_o        (priv_o),
  .target_pc_o   (target_pc_o)
);

// File: tb/tb_trap_return_unit.sv
module tb_trap_return_unit;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ret_valid_i = 1'b0;
  logic            ret_is_m_i = 1'b0;
  logic [1:0]      cur_priv_i = 2'd3;
  logic [XLEN-1:0] status_i = '0;
  logic [XLEN-1:0] sepc_i = '0;
  logic [XLEN-1:0] mepc_i = '0;
  logic            rvc_en_i = 1'b0;
  logic            ret_done_o, ret_fault_o;
  logic [3:0]      fault_cause_o;
  logic [XLEN-1:0] status_o, target_pc_o;
  logic [1:0]      priv_o;

  int checks = 0;
  int errors = 0;

  logic            e_done, e_fault;
  logic [3:0]      e_cause;
  logic [XLEN-1:0] e_status, e_pc;
  logic [1:0]      e_priv;

  always #10 clk = ~clk;

  trap_return_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .ret_valid_i(ret_valid_i), .ret_is_m_i(ret_is_m_i),
    .cur_priv_i(cur_priv_i), .status_i(status_i), .sepc_i(sepc_i), .mepc_i(mepc_i),
    .rvc_en_i(rvc_en_i), .ret_done_o(ret_done_o), .ret_fault_o(ret_fault_o),
    .fault_cause_o(fault_cause_o), .status_o(status_o), .priv_o(priv_o),
    .target_pc_o(target_pc_o)
  );

  task automatic chk(input string req, input string what, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic is_m, input logic [1:0] cur, input logic [XLEN-1:0] st,
                       input logic [XLEN-1:0] sepc, input logic [XLEN-1:0] mepc,
                       input logic rvc);
    logic            ill, mis;
    logic [XLEN-1:0] epc;
    logic [1:0]      pp;
    ill = is_m ? (cur < 2'd3) : (cur < 2'd1);
    epc = is_m ? mepc : sepc;
    mis = !rvc && (epc[1:0] != 2'b00);
    e_done = 1'b0; e_fault = 1'b0;
    if (ill || mis) begin
      e_fault  = 1'b1;
      e_cause  = ill ? 4'd2 : 4'd0;
      e_status = st;
      e_priv   = cur;
    end else begin
      e_done   = 1'b1;
      e_status = st;
      if (is_m) begin
        pp = st[12:11];
        e_priv = (pp == 2'd2) ? 2'd1 : pp;
        e_status[3] = st[7];
        e_status[7] = 1'b0;
        e_status[12:11] = 2'b00;
      end else begin
        e_priv = {1'b0, st[8]};
        e_status[1] = st[5];
        e_status[5] = 1'b0;
        e_status[8] = 1'b0;
      end
      e_pc = epc;
    end
  endtask

  task automatic compare_all(input logic is_m);
    string tf, ts, tp;
    tf = e_fault ? ((e_cause == 4'd0) ? "R4" : (is_m ? "R3" : "R2")) : "R13";
    ts = e_done ? (is_m ? "R6" : "R7") : tf;
    tp = e_done ? "R8" : tf;
    chk(tf, "done", XLEN'(ret_done_o), XLEN'(e_done));
    chk(tf, "fault", XLEN'(ret_fault_o), XLEN'(e_fault));
    chk(tf, "cause", XLEN'(fault_cause_o), XLEN'(e_cause));
    chk(ts, "status", status_o, e_status);
    chk(tp, "priv", XLEN'(priv_o), XLEN'(e_priv));
    chk(e_done ? "R9" : "R12", "target_pc", target_pc_o, e_pc);
  endtask

  task automatic do_req(input logic is_m, input logic [1:0] cur, input logic [XLEN-1:0] st,
                        input logic [XLEN-1:0] sepc, input logic [XLEN-1:0] mepc,
                        input logic rvc);
    @(negedge clk);
    ret_valid_i = 1'b1; ret_is_m_i = is_m; cur_priv_i = cur;
    status_i = st; sepc_i = sepc; mepc_i = mepc; rvc_en_i = rvc;
    model(is_m, cur, st, sepc, mepc, rvc);
    @(negedge clk);
    ret_valid_i = 1'b0;
    compare_all(is_m);
  endtask

  task automatic idle_check();
    @(negedge clk);
    ret_valid_i = 1'b0;
    status_i = $urandom();
    @(negedge clk);
    chk("R12", "idle done", XLEN'(ret_done_o), '0);
    chk("R12", "idle fault", XLEN'(ret_fault_o), '0);
    chk("R12", "idle pc hold", target_pc_o, e_pc);
    chk("R12", "idle cause hold", XLEN'(fault_cause_o), XLEN'(e_cause));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] st;
    void'($urandom(32'h1ced));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", XLEN'(ret_done_o), '0);
    chk("R1", "fault", XLEN'(ret_fault_o), '0);
    chk("R1", "priv", XLEN'(priv_o), 32'd3);
    chk("R1", "status", status_o, '0);
    chk("R1", "pc", target_pc_o, '0);
    chk("R1", "cause", XLEN'(fault_cause_o), '0);
    e_cause = 4'd0; e_pc = '0;

    // R2 supervisor return from user mode
    do_req(1'b0, 2'd0, 32'h0000_01A2, 32'h100, 32'h200, 1'b0);
    chk("R2", "illegal cause", XLEN'(fault_cause_o), 32'd2);
    // R3 machine return from supervisor
    do_req(1'b1, 2'd1, 32'h0000_1888, 32'h100, 32'h200, 1'b0);
    chk("R3", "illegal cause", XLEN'(fault_cause_o), 32'd2);
    // R4 misaligned saved PC, compressed off
    do_req(1'b1, 2'd3, 32'h0000_0880, 32'h100, 32'h202, 1'b0);
    chk("R4", "misaligned cause", XLEN'(fault_cause_o), 32'd0);
    do_req(1'b0, 2'd1, 32'h0000_0020, 32'h101, 32'h200, 1'b0);
    chk("R4", "misaligned bit0", XLEN'(ret_fault_o), 32'd1);
    // R5 same PC accepted when compressed is on
    do_req(1'b1, 2'd3, 32'h0000_0880, 32'h100, 32'h202, 1'b1);
    chk("R5", "accepted", XLEN'(ret_done_o), 32'd1);
    // R11 both faults at once: illegal wins
    do_req(1'b1, 2'd0, 32'h0000_0000, 32'h103, 32'h203, 1'b0);
    chk("R11", "precedence cause", XLEN'(fault_cause_o), 32'd2);
    // R8 reserved previous level maps to supervisor
    do_req(1'b1, 2'd3, 32'h0000_1080, 32'h100, 32'h400, 1'b0);
    chk("R8", "rsvd->S", XLEN'(priv_o), 32'd1);
    // R8 supervisor return to supervisor
    do_req(1'b0, 2'd3, 32'h0000_0120, 32'h800, 32'h400, 1'b0);
    chk("R8", "spp=1", XLEN'(priv_o), 32'd1);
    // R10 unrelated bits survive
    do_req(1'b1, 2'd3, 32'hFFFF_E755, 32'h0, 32'h4, 1'b0);
    chk("R10", "other bits", status_o & ~32'h0000_1888, 32'hFFFF_E755 & ~32'h0000_1888);
    idle_check();

    // R13 no result before the clock edge
    @(negedge clk);
    ret_valid_i = 1'b1; ret_is_m_i = 1'b1; cur_priv_i = 2'd3;
    status_i = 32'h80; mepc_i = 32'h3000; rvc_en_i = 1'b0;
    model(1'b1, 2'd3, 32'h80, sepc_i, 32'h3000, 1'b0);
    #1;
    chk("R13", "not before edge", XLEN'(ret_done_o), '0);
    @(negedge clk);
    ret_valid_i = 1'b0;
    chk("R13", "after edge", XLEN'(ret_done_o), 32'd1);
    compare_all(1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] cur;
      cur = 2'($urandom_range(0, 2));
      if (cur == 2'd2) cur = 2'd3;
      st = $urandom();
      do_req(1'($urandom()), cur, st, $urandom(), $urandom(), 1'($urandom()));
      if (($urandom() & 7) == 0) idle_check();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule